// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block plays the memory-device side of a three-wire serial EEPROM link. Software does not drive real pins. It writes a control register, and each write carries new levels for chip select, serial clock and data-in. The block compares each write with the levels it saw last, works out which edges happened, and steps its protocol engine. The one response bit, data-out, is held in a register that software can read back.

A transaction starts with a chip-select rise. Leading zero bits follow, then a start bit of 1. After that come a two-bit command and an address of `ADDR_W` bits, then a data phase. A read sends a dummy zero after the address, then the selected 16-bit word, most significant bit first. A write collects data bits and stores them only when chip select falls. The array holds 2^`ADDR_W` words. Full reset clears the array as well as the protocol state.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While `rst_n` is low, every array word becomes 0, `dout` becomes 1 and the protocol returns to idle with no start bit seen.
- R2: A register write with `ctl_cs` = 0 while chip select is already low has no effect. A write that raises `ctl_cs` only records the new chip-select and clock levels.
- R3: Protocol bits are taken only on a register write where chip select stays high and the recorded clock goes from 1 to 0. A clock rise, or a write that leaves the clock level unchanged, takes no bit.
- R4: Data-in zeros on sampling edges are ignored until the first 1. That 1 is the start bit and begins the command phase.
- R5: After the start bit, the next two sampled bits form the command, first bit in the MSB. Then `ADDR_W` sampled bits form the address, MSB first. Command 2'b10 is read and 2'b01 is write.
- R6: On the sampling edge that captures the last address bit, `dout` becomes 0.
- R7: In a read, the 16 sampling edges after the address edge present the addressed word on `dout`, bit 15 first, and data-in is ignored. The next edge gives 0, and the edge after that sends the engine idle with `dout` at 0.
- R8: In a write, each sampled data bit shifts into a 16-bit holding value that was cleared at the address edge. Only the last 16 bits are kept. The value goes into the addressed word when chip select falls. Commands 2'b00 and 2'b11 never change the array.
- R9: A chip-select fall clears the start flag, command, address, holding value, bit count and phase, and sets `dout` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full reset, array included |
| ctl_we | input | 1 | Control register write strobe |
| ctl_cs | input | 1 | Chip-select level carried by the write |
| ctl_sk | input | 1 | Serial-clock level carried by the write |
| ctl_di | input | 1 | Data-in level carried by the write |
| dout | output | 1 | Data-out bit of the responder |

## Verification
Some properties are checked on every cycle: the dummy zero when the engine moves from address to data, `dout` going high on every chip-select fall, protocol state holding still on writes that have no clock fall, the phase staying idle until a start bit, and the read bit count staying bounded. Other behaviour can only be shown by the bench scenarios. These cover the bit order of command, address and data, a write committed on release and read back later, commands that leave memory untouched, partial and over-long write data, extra read clocks, and the array cleared by full reset.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  logic ctl_cs,
  input  logic ctl_sk,
  input  logic ctl_di,
  output logic dout
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WORD_W + ADDR_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_ADDR, PH_DATA} phase_t;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              cs_q, sk_q, start_q, dout_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] shreg, rdata;
  logic [CNT_W-1:0]  cnt;
  phase_t            phase;

  logic              cs_fall, sk_fall, rd_phase, commit;
  logic [WORD_W-1:0] sh_next, rd_shift;
  logic [CNT_W-1:0]  cnt_next;

  assign cs_fall  = ctl_we && !ctl_cs && cs_q;
  assign sk_fall  = ctl_we && ctl_cs && cs_q && sk_q && !ctl_sk;
  assign rd_phase = (phase == PH_DATA) && (op_q == OP_RD);
  assign commit   = cs_fall && (phase == PH_DATA) && (op_q == OP_WR);
  assign sh_next  = {shreg[WORD_W-2:0], ctl_di};
  assign cnt_next = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign rd_shift = rdata << cnt;
  assign dout     = dout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      mem[addr_q] <= shreg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b0; sk_q <= 1'b0; start_q <= 1'b0; dout_q <= 1'b1;
      op_q <= '0; addr_q <= '0; shreg <= '0; rdata <= '0;
      cnt <= '0; phase <= PH_IDLE;
    end else if (ctl_we && (ctl_cs || cs_q)) begin
      cs_q <= ctl_cs;
      sk_q <= ctl_sk;
      if (cs_fall) begin
        sk_q <= 1'b0; start_q <= 1'b0; dout_q <= 1'b1;
        op_q <= '0; addr_q <= '0; shreg <= '0; rdata <= '0;
        cnt <= '0; phase <= PH_IDLE;
      end else if (sk_fall) begin
        if (!start_q) begin
          if (ctl_di) begin
            start_q <= 1'b1;
            cnt     <= '0;
            shreg   <= '0;
            phase   <= PH_OPC;
          end
        end else begin
          if (!rd_phase) begin
            shreg <= sh_next;
            cnt   <= cnt_next;
          end
          case (phase)
            PH_OPC: if (cnt_next == CNT_W'(2)) begin
              op_q  <= sh_next[1:0];
              shreg <= '0;
              cnt   <= '0;
              phase <= PH_ADDR;
            end
            PH_ADDR: if (cnt_next == CNT_W'(ADDR_W)) begin
              addr_q <= sh_next[ADDR_W-1:0];
              rdata  <= mem[sh_next[ADDR_W-1:0]];
              shreg  <= '0;
              cnt    <= '0;
              phase  <= PH_DATA;
              dout_q <= 1'b0;
            end
            PH_DATA: if (op_q == OP_RD) begin
              dout_q <= rd_shift[WORD_W-1];
              if (cnt > CNT_W'(WORD_W)) phase <= PH_IDLE;
              else cnt <= cnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_dummy_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_ADDR) |-> !dout_q);

  p_release_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> (dout_q && phase == PH_IDLE && !start_q));

  p_quiet_no_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_cs && cs_q && !(sk_q && !ctl_sk)) |=>
      ($stable(phase) && $stable(cnt) && $stable(dout_q) && $stable(shreg)));

  p_idle_until_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> (phase == PH_IDLE && cnt == '0));

  p_read_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> (cnt <= CNT_W'(WORD_W + 1)));

  p_no_we_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable(cs_q) && $stable(sk_q) && $stable(dout_q)));
endmodule

// File: tb/tb_mw_eeprom_slave.sv
module tb_mw_eeprom_slave;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_cs = 1'b0, ctl_sk = 1'b0, ctl_di = 1'b0;
  logic dout;
  logic [15:0] ref_mem [DEPTH];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mw_eeprom_slave #(.ADDR_W(ADDR_W), .WORD_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_cs(ctl_cs),
    .ctl_sk(ctl_sk), .ctl_di(ctl_di), .dout(dout));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic cs, logic sk, logic di);
    @(negedge clk);
    ctl_we = 1'b1; ctl_cs = cs; ctl_sk = sk; ctl_di = di;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic bitc(logic di);
    wr(1'b1, 1'b1, di);
    wr(1'b1, 1'b0, di);
  endtask

  task automatic head(logic [1:0] op, logic [ADDR_W-1:0] a);
    bitc(1'b1);
    bitc(op[1]); bitc(op[0]);
    for (int i = ADDR_W - 1; i >= 0; i--) bitc(a[i]);
  endtask

  task automatic read_body(logic [ADDR_W-1:0] a, bit rnd_di, output logic [15:0] got);
    head(2'b10, a);
    check("R6 dummy zero", 16'(dout), 16'h0);
    for (int i = 15; i >= 0; i--) begin
      bitc(rnd_di ? 1'($urandom % 2) : 1'b0);
      got[i] = dout;
    end
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, string req);
    logic [15:0] got;
    wr(1'b1, 1'b0, 1'b0);
    read_body(a, 1'b1, got);
    check(req, got, ref_mem[a]);
    wr(1'b0, 1'b0, 1'b0);
    check("R9 dout high after release", 16'(dout), 16'h1);
  endtask

  task automatic do_write(logic [1:0] op, logic [ADDR_W-1:0] a, logic [15:0] d, int nbits);
    logic [15:0] held = '0;
    wr(1'b1, 1'b0, 1'b0);
    head(op, a);
    for (int i = nbits - 1; i >= 0; i--) begin
      logic b = (i < 16) ? d[i] : 1'($urandom % 2);
      bitc(b);
      held = {held[14:0], b};
    end
    wr(1'b0, 1'b0, 1'b0);
    if (op == 2'b01) ref_mem[a] = held;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 dout after reset", 16'(dout), 16'h1);
    do_read(6'd5, "R1 array zero after reset");

    // R2: writes with chip select low while deselected do nothing
    wr(1'b0, 1'b1, 1'b1); wr(1'b0, 1'b0, 1'b1); wr(1'b0, 1'b1, 1'b0);
    check("R2 ignored deselected writes", 16'(dout), 16'h1);

    // directed writes: full, partial, over-long
    do_write(2'b01, 6'd0, 16'hBEEF, 16);
    do_read(6'd0, "R8 full word write");
    do_write(2'b01, 6'd63, 16'h00A5, 8);
    do_read(6'd63, "R8 partial write keeps shifted bits");
    do_write(2'b01, 6'd7, 16'h1234, 21);
    do_read(6'd7, "R8 long write keeps last 16 bits");
    do_write(2'b11, 6'd0, 16'h0000, 16);
    do_write(2'b00, 6'd7, 16'hFFFF, 16);
    do_read(6'd0, "R8 opcode 11 leaves memory");
    do_read(6'd7, "R8 opcode 00 leaves memory");

    // R3/R4: rising clock with di=1 and leading zeros do not start
    wr(1'b1, 1'b0, 1'b0);
    wr(1'b1, 1'b1, 1'b1); wr(1'b1, 1'b1, 1'b1);
    wr(1'b1, 1'b0, 1'b0);
    bitc(1'b0); bitc(1'b0);
    check("R4 idle before start", 16'(dout), 16'h1);
    read_body(6'd0, 1'b0, got);
    check("R3 R4 R5 read after leading zeros", got, 16'hBEEF);
    // R7: two more edges give 0 and go idle
    bitc(1'b1);
    check("R7 bit after word", 16'(dout), 16'h0);
    bitc(1'b1);
    check("R7 idle after read", 16'(dout), 16'h0);
    bitc(1'b1); bitc(1'b0);
    check("R7 stays idle", 16'(dout), 16'h0);
    wr(1'b0, 1'b0, 1'b0);
    check("R9 release after long read", 16'(dout), 16'h1);

    // random writes and read-back
    for (int n = 0; n < 120; n++) begin
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      logic [1:0] op = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      do_write(op, a, 16'($urandom), 16);
    end
    for (int n = 0; n < 80; n++) do_read(ADDR_W'($urandom), "R7 R8 random read-back");

    // R1: full reset clears written data
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    check("R1 dout after second reset", 16'(dout), 16'h1);
    do_read(6'd0, "R1 array cleared");
    do_read(6'd7, "R1 array cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule